// File: doc/BRIEF.md
# Serial DAC Input Register Front End

This block is the digital front end of a serial-input digital-to-analog converter. A host writes frames over three wires: an active-low frame select, a serial clock that idles high, and a data line. The data line is sampled on each falling serial clock edge. All three wires pass through a synchronizer into the system clock domain, and the block detects their edges there. It assembles each frame MSB first and decodes a two-bit power-down field and the data field. When a frame completes, it updates the parallel DAC code and the output mode.

A frame that is cut short by the select line has no effect. The one exception is a software-reset frame whose control bits have already arrived as all ones. A frame made entirely of ones returns the block to its power-on state and raises a one-cycle reset strobe. The frame length is a parameter: 16 bits (2 control and 14 data) or 24 bits (6 ignored, 2 control and 16 data). A second parameter sets the power-on code to zero scale or midscale.

Top module: `dacfe_top`

## Requirements
- R1: After reset, the code is the power-on default, the mode is normal (00) and the reset strobe is low.
- R2: In a 16-bit frame, the first two bits shifted in are the control field (upper bit first), followed by 14 data bits MSB first. The code takes the data field when the 16th falling serial clock edge arrives with select low.
- R3: Mode encoding is 00 normal, 01 output loaded to ground through 100 kΩ, and 10 output three-stated. A completed frame with control field 11 loads the code and leaves the mode unchanged. The mode output never shows 11.
- R4: If select rises before the last edge of a frame, neither the code nor the mode changes, and the reset strobe stays low. This holds for every cut-off position, and also for an all-ones frame cut before its control bits are complete.
- R5: A completed frame of all ones sets the code to the power-on default and the mode to normal, and raises the reset strobe for exactly one system clock cycle.
- R6: The abort is not honoured for a frame that is cut short after its received bits have covered the whole control field and every received bit is 1. The block carries out the software reset anyway.
- R7: Serial clock edges after the last bit of a frame are ignored until select rises and falls again.
- R8: The code and the mode change only on a completed frame or on a software reset.
- R9: In a 24-bit frame, the code takes the lowest 16 bits and the control field is bits 17:16. Bits 23:18 have no effect. In this variant the control field ends after 8 received bits.
- R10: With the midscale option, the power-on and software-reset code has only the data MSB set (0x8000 for 16 data bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sclkIn | input | 1 | Serial clock, asynchronous, data taken on falling edges |
| syncNIn | input | 1 | Active-low frame select, asynchronous |
| dinIn | input | 1 | Serial data, asynchronous |
| dacCode | output | DATA_W | Parallel DAC code (14 bits for 16-bit frames, 16 bits for 24-bit frames) |
| pwrMode | output | 2 | Output mode: 00 normal, 01 100 kΩ to ground, 10 three-state |
| swResetPulse | output | 1 | One-cycle strobe on a software reset |

## Verification
The bench sweeps the abort point across every bit position of a frame. An off-by-one counter would commit one edge early or late, or would let a partial frame load. Walking-one data and all four control codes expose a swapped or shifted field, and a design that accepted the reserved code would change the mode. All-ones frames are sent complete, cut just after the control field, and cut inside it. This separates a design that never resets, one that resets on any leading 1, and one that still honours the abort. The 24-bit midscale instance covers ignored upper bits, and trailing clock edges after a frame would corrupt the code if they were shifted in.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_PULLDOWN = 2'b01,
    MODE_HIZ      = 2'b10
  } out_mode_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic clear;    // frame start or abort: empty the shift register
    logic shift;    // take one bit (not the last one)
    logic commit;   // last bit of a full frame is on bitIn
    logic swReset;  // load power-on state
    logic bitIn;    // synchronized data bit
  } strobe_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= INIT;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CTRL_BITS  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkS,
  input  logic    syncNS,
  input  logic    dinS,
  output strobe_t stb
);

  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CTRL_CNT = CW'(CTRL_BITS);
  localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_BITS);

  logic sclkPrev, syncPrev;
  logic active, onesSoFar;
  logic [CW-1:0] bitCount;
  logic syncFall, syncRise, sclkFall;

  assign syncFall = syncPrev & ~syncNS;
  assign syncRise = ~syncPrev & syncNS;
  assign sclkFall = sclkPrev & ~sclkS;

  always_comb begin
    stb = '0;
    stb.bitIn = dinS;
    if (syncFall) begin
      stb.clear = 1'b1;
    end else if (syncRise) begin
      stb.clear = 1'b1;
      // a reset frame whose control field is all ones runs to completion
      if (active && onesSoFar && bitCount >= CTRL_CNT && bitCount < FULL_CNT)
        stb.swReset = 1'b1;
    end else if (!syncNS && active && sclkFall) begin
      if (bitCount == LAST_IDX) begin
        stb.commit  = 1'b1;
        stb.swReset = onesSoFar & dinS;
      end else begin
        stb.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b1;
      syncPrev  <= 1'b1;
      active    <= 1'b0;
      onesSoFar <= 1'b0;
      bitCount  <= '0;
    end else begin
      sclkPrev <= sclkS;
      syncPrev <= syncNS;
      if (syncFall) begin
        active    <= 1'b1;
        onesSoFar <= 1'b1;
        bitCount  <= '0;
      end else if (syncRise) begin
        active <= 1'b0;
      end else if (stb.commit) begin
        active   <= 1'b0;
        bitCount <= FULL_CNT;
      end else if (stb.shift) begin
        bitCount  <= bitCount + 1'b1;
        onesSoFar <= onesSoFar & dinS;
      end
    end
  end

endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter logic [DATA_W-1:0] DEFAULT_CODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] dacCode,
  output logic [1:0]        pwrMode,
  output logic              swResetPulse
);

  // only control field and data are kept; older bits fall off the top
  localparam int KEEP_W = DATA_W + 1;

  logic [KEEP_W-1:0] shiftQ;
  logic [KEEP_W:0]   word;
  logic [1:0]        ctrlField;
  out_mode_e         modeQ;

  assign word      = {shiftQ, stb.bitIn};
  assign ctrlField = word[DATA_W+1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ       <= '0;
      dacCode      <= DEFAULT_CODE;
      modeQ        <= MODE_NORMAL;
      swResetPulse <= 1'b0;
    end else begin
      swResetPulse <= stb.swReset;
      if (stb.clear || stb.commit) shiftQ <= '0;
      else if (stb.shift) shiftQ <= {shiftQ[KEEP_W-2:0], stb.bitIn};

      if (stb.swReset) begin
        dacCode <= DEFAULT_CODE;
        modeQ   <= MODE_NORMAL;
      end else if (stb.commit) begin
        dacCode <= word[DATA_W-1:0];
        case (ctrlField)
          2'b00:   modeQ <= MODE_NORMAL;
          2'b01:   modeQ <= MODE_PULLDOWN;
          2'b10:   modeQ <= MODE_HIZ;
          default: modeQ <= modeQ;
        endcase
      end
    end
  end

  assign pwrMode = modeQ;

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS     = 16,
  parameter bit MIDSCALE_RESET = 1'b0,
  parameter int SYNC_STAGES    = 2,
  localparam int DATA_W        = (FRAME_BITS >= 24) ? 16 : 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              syncNIn,
  input  logic              dinIn,
  output logic [DATA_W-1:0] dacCode,
  output logic [1:0]        pwrMode,
  output logic              swResetPulse
);

  localparam int CTRL_BITS = FRAME_BITS - DATA_W;
  localparam logic [DATA_W-1:0] DEFAULT_CODE =
    MIDSCALE_RESET ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  logic [2:0] pinsS;
  strobe_t    stb;

  dacfe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({sclkIn, syncNIn, dinIn}),
    .syncOut(pinsS)
  );

  dacfe_ctrl #(.FRAME_BITS(FRAME_BITS), .CTRL_BITS(CTRL_BITS)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .sclkS (pinsS[2]),
    .syncNS(pinsS[1]),
    .dinS  (pinsS[0]),
    .stb   (stb)
  );

  dacfe_datapath #(.DATA_W(DATA_W), .DEFAULT_CODE(DEFAULT_CODE)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .dacCode     (dacCode),
    .pwrMode     (pwrMode),
    .swResetPulse(swResetPulse)
  );

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter logic [DATA_W-1:0] DEFAULT_CODE = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dacCode,
  input logic [1:0]        pwrMode,
  input logic              swResetPulse,
  input strobe_t           stb
);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commit && !stb.swReset) |=> $stable(dacCode));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.commit && !stb.swReset) |=> $stable(pwrMode));

  // R3
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrMode != 2'b11);

  // R5
  swreset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |-> (dacCode == DEFAULT_CODE && pwrMode == 2'b00));

  // R5
  swreset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    swResetPulse |=> !swResetPulse);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clear, stb.shift, stb.commit}));

endmodule

bind dacfe_top dacfe_chk #(.DATA_W(DATA_W), .DEFAULT_CODE(DEFAULT_CODE)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .dacCode     (dacCode),
  .pwrMode     (pwrMode),
  .swResetPulse(swResetPulse),
  .stb         (stb)
);

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkA = 1'b1, syncA = 1'b1, dinA = 1'b0;
  logic sclkB = 1'b1, syncB = 1'b1, dinB = 1'b0;
  logic [13:0] codeA;
  logic [15:0] codeB;
  logic [1:0]  modeA, modeB;
  logic        pulseA, pulseB;

  int errors = 0, checks = 0;
  int pulseCntA = 0, pulseCntB = 0;
  int expCodeA = 0, expModeA = 0, expPulseA = 0;
  int expCodeB = 32'h8000, expModeB = 0, expPulseB = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacfe_top dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkA), .syncNIn(syncA), .dinIn(dinA),
    .dacCode(codeA), .pwrMode(modeA), .swResetPulse(pulseA)
  );

  dacfe_top #(.FRAME_BITS(24), .MIDSCALE_RESET(1'b1)) dut24_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkB), .syncNIn(syncB), .dinIn(dinB),
    .dacCode(codeB), .pwrMode(modeB), .swResetPulse(pulseB)
  );

  always @(posedge clk) begin
    if (pulseA) pulseCntA <= pulseCntA + 1;
    if (pulseB) pulseCntB <= pulseCntB + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input bit sel, input logic s, input logic c, input logic d);
    if (sel) begin syncB = s; sclkB = c; dinB = d; end
    else     begin syncA = s; sclkA = c; dinA = d; end
  endtask

  // reference outcome of one frame, from the requirements
  task automatic model(input bit sel, input logic [23:0] w, input int sent);
    int nb = sel ? 24 : 16;
    int dw = sel ? 16 : 14;
    int cb = nb - dw;
    int defc = sel ? 32'h8000 : 0;
    bit ones = 1;
    for (int i = 0; i < sent; i++) if (!w[nb-1-i]) ones = 0;
    if (sent == nb) begin
      if (ones) begin
        if (sel) begin expCodeB = defc; expModeB = 0; expPulseB++; end
        else     begin expCodeA = defc; expModeA = 0; expPulseA++; end
      end else begin
        int pd = (w >> dw) & 3;
        int cd = w & ((1 << dw) - 1);
        if (sel) begin expCodeB = cd; if (pd != 3) expModeB = pd; end
        else     begin expCodeA = cd; if (pd != 3) expModeA = pd; end
      end
    end else if (sent >= cb && ones) begin
      if (sel) begin expCodeB = defc; expModeB = 0; expPulseB++; end
      else     begin expCodeA = defc; expModeA = 0; expPulseA++; end
    end
  endtask

  // send `sent` bits of w MSB first, then `extra` trailing edges, then raise select
  task automatic frame(input bit sel, input logic [23:0] w, input int sent, input int extra);
    int nb = sel ? 24 : 16;
    pins(sel, 1'b0, 1'b1, 1'b0);
    waitClk(HALF_SCLK);
    for (int i = 0; i < sent + extra; i++) begin
      logic b = (i < nb) ? w[nb-1-i] : 1'b0;
      pins(sel, 1'b0, 1'b1, b);
      waitClk(HALF_SCLK);
      pins(sel, 1'b0, 1'b0, b);
      waitClk(HALF_SCLK);
    end
    pins(sel, 1'b0, 1'b1, 1'b0);
    waitClk(HALF_SCLK);
    pins(sel, 1'b1, 1'b1, 1'b0);
    waitClk(10);
    model(sel, w, (sent > nb) ? nb : sent);
  endtask

  task automatic checkA(input string tag);
    check({tag, " code"}, int'(codeA), expCodeA);
    check({tag, " mode"}, int'(modeA), expModeA);
    check({tag, " pulses"}, pulseCntA, expPulseA);
  endtask

  task automatic checkB(input string tag);
    check({tag, " code"}, int'(codeB), expCodeB);
    check({tag, " mode"}, int'(modeB), expModeB);
    check({tag, " pulses"}, pulseCntB, expPulseB);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    check("R1 code", int'(codeA), 0);
    check("R1 mode", int'(modeA), 0);
    check("R1 strobe", int'(pulseA), 0);
    check("R10 midscale code", int'(codeB), 32'h8000);

    // R2 walking one through the data field, normal mode
    for (int i = 0; i < 14; i++) begin
      frame(0, 24'(1 << i), 16, 0);
      checkA("R2 walk");
    end
    frame(0, 24'h2AAA, 16, 0); checkA("R2 alt");
    frame(0, 24'h1555, 16, 0); checkA("R2 alt");

    // R3 every control code, with the reserved one last
    for (int pd = 0; pd < 4; pd++) begin
      frame(0, 24'((pd << 14) | (16'h0F0F + pd)), 16, 0);
      checkA("R3 mode");
    end
    frame(0, 24'h8123, 16, 0); checkA("R3 hiz");
    frame(0, 24'hC777, 16, 0); checkA("R3 reserved keeps mode");

    // R4 cut-off at every position
    frame(0, 24'h5234, 16, 0); checkA("R4 preload");
    for (int k = 0; k < 16; k++) begin
      frame(0, 24'h9ABC, k, 0);
      checkA("R4 abort");
    end
    frame(0, 24'hFFFF, 1, 0); checkA("R4 ones cut inside control");

    // R7 trailing edges ignored
    frame(0, 24'h4321, 16, 5); checkA("R7 trailing");

    // R5 full all-ones frame
    frame(0, 24'hFFFF, 16, 0); checkA("R5 reset frame");

    // R6 all-ones frame cut after the control field
    frame(0, 24'h2ABC, 16, 0); checkA("R6 preload");
    frame(0, 24'hFFFF, 5, 0); checkA("R6 abort ignored");
    frame(0, 24'h6001, 16, 0); checkA("R6 reload");
    frame(0, 24'hFFFF, 2, 0); checkA("R6 abort at boundary");
    frame(0, 24'h1FFF, 16, 0); checkA("R6 reload");
    frame(0, 24'hFFFF, 15, 0); checkA("R6 abort late");

    // R9 / R10 24-bit variant
    frame(1, 24'hFC_ABCD, 24, 0); checkB("R9 upper ignored");
    frame(1, 24'h02_1234, 24, 0); checkB("R9 hiz");
    frame(1, 24'h57_8001, 24, 0); checkB("R9 reserved");
    frame(1, 24'h00_FFFF, 24, 0); checkB("R9 full data");
    frame(1, 24'h01_0000, 24, 3); checkB("R9 trailing");
    frame(1, 24'h03_5555, 20, 0); checkB("R9 abort");
    frame(1, 24'hFF_FFFF, 7, 0); checkB("R9 ones cut inside control");
    frame(1, 24'hFF_FFFF, 24, 0); checkB("R10 reset to midscale");
    frame(1, 24'h01_0042, 24, 0); checkB("R10 preload");
    frame(1, 24'hFF_FFFF, 12, 0); checkB("R10 abort ignored reset");
    check("R8 A untouched by B", int'(codeA), expCodeA);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule